// File: doc/BRIEF.md
# Posting and Prefetch Line Buffers

This unit sits on the bridge between a narrow expansion-bus master port and a 32-bit system-bus burst master port. It only handles memory cycles that the expansion side starts toward system memory. It holds a small set of 16-byte lines. Each line is aligned to a 16-byte address boundary and can be empty, posted (holding gathered write data), being filled, or prefetched (holding read data).

Expansion writes of byte, word or dword size are merged into a posted line at their byte lanes. A line goes out as one 4-beat dword burst in one of three cases: the line becomes complete, its buffer is needed for another line, or a flush is requested. A read that misses fetches the whole line with one 4-beat read burst. Later reads inside that line are answered locally. The expansion port holds off requests with a wait signal whenever the unit is busy on the system side.

Top module: `line_buffer_unit`

## Requirements
- R1: After reset every line is empty, `exp_wait_o` and `sys_valid_o` are low, and the first read of any address causes a fill burst.
- R2: An accepted write merges into the matching line only the byte lanes whose `exp_be_i` bit is set, where bit k is byte k of the dword selected by `exp_addr_i[3:2]`. `exp_addr_i[1:0]` is ignored.
- R3: When a posted line has all 16 bytes written, it is flushed without any request as one write burst of 4 beats. The burst starts at the line base, the address rises by 4 per beat, and every `sys_be_o` is 4'hf.
- R4: A pulse on `flush_i` flushes every posted line as a 4-beat burst. Beats of unwritten bytes carry cleared `sys_be_o` bits, and all-clear beats are still issued.
- R5: A read miss issues a 4-beat read burst (`sys_we_o` low, `sys_be_o` 4'hf) from the line base. The read then returns `sys_rdata_i` of its dword. Later reads in that line cause no system activity.
- R6: Before a read miss starts its fill, all posted lines are flushed, so every flush beat precedes the fill beats.
- R7: A write to a prefetched line discards the prefetched data. A later read of that line first flushes the write and then fetches the line again.
- R8: Up to 4 different lines are held without system activity, and a free line is taken lowest index first. With all lines in use, a new line takes the victim by round-robin starting from line 0 after reset. A posted victim is flushed before reuse.
- R9: `exp_wait_o` is high exactly while a request is present and not accepted. It is always high during a system burst. A write to an already held posted line, or a read hit, is accepted without wait.
- R10: A beat completes only when `sys_valid_o` and `sys_ready_i` are both high. While `sys_ready_i` is low, address, data, byte enables and direction hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exp_req_i | input | 1 | Expansion access request, held until accepted |
| exp_we_i | input | 1 | 1 = write, 0 = read |
| exp_addr_i | input | ADDR_W | Byte address (dword taken from bits 3:2) |
| exp_be_i | input | 4 | Byte lanes of the dword for writes |
| exp_wdata_i | input | 32 | Write data |
| exp_wait_o | output | 1 | Request not accepted this cycle |
| exp_rdata_o | output | 32 | Read data, valid in the accepting cycle |
| flush_i | input | 1 | Flush all posted lines |
| sys_valid_o | output | 1 | Burst beat valid |
| sys_ready_i | input | 1 | Beat accepted by the system side |
| sys_we_o | output | 1 | 1 = write burst, 0 = read burst |
| sys_addr_o | output | ADDR_W | Dword address of the current beat |
| sys_be_o | output | 4 | Byte enables of the current beat |
| sys_wdata_o | output | 32 | Write data of the current beat |
| sys_rdata_i | input | 32 | Read data of the current beat |
| sys_last_o | output | 1 | Final beat of the burst |

## Verification
The bench uses the default build: four lines of 16 bytes and 32-bit addresses. With these values, five distinct lines are enough to force round-robin victim reuse of a posted line, and full, partial and single-dword lines can all be written in a few accesses. A ready pattern that drops every other cycle checks that beats hold and stay in order under backpressure.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
  typedef enum logic [1:0] {LN_EMPTY, LN_POSTED, LN_PREFETCH, LN_FILLING} line_st_e;
  typedef enum logic [1:0] {FS_IDLE, FS_FLUSH, FS_FILL} fsm_e;
endpackage

// File: rtl/lbu_line.sv
module lbu_line
  import lbu_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int TAG_W      = 28
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic                    st_set_i,
  input  line_st_e                st_i,
  input  logic                    wr_i,
  input  logic [$clog2(LINE_BYTES/4)-1:0] wr_word_i,
  input  logic [3:0]              wr_be_i,
  input  logic [31:0]             wr_data_i,
  input  logic                    fill_i,
  input  logic [$clog2(LINE_BYTES/4)-1:0] fill_word_i,
  input  logic [31:0]             fill_data_i,
  output line_st_e                st_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic [LINE_BYTES-1:0]   mask_o,
  output logic [LINE_BYTES*8-1:0] data_o
);
  localparam int WORDS = LINE_BYTES / 4;

  logic [LINE_BYTES-1:0] mask_n;

  always_comb begin
    mask_n = load_i ? '0 : mask_o;
    for (int w = 0; w < WORDS; w++) begin
      if (wr_i && wr_word_i == w[$bits(wr_word_i)-1:0]) mask_n[w*4 +: 4] = mask_n[w*4 +: 4] | wr_be_i;
      if (fill_i && fill_word_i == w[$bits(fill_word_i)-1:0]) mask_n[w*4 +: 4] = 4'hf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o   <= LN_EMPTY;
      tag_o  <= '0;
      mask_o <= '0;
    end else begin
      if (st_set_i) st_o <= st_i;
      if (load_i) tag_o <= tag_i;
      mask_o <= mask_n;
    end
  end

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_byte
    localparam int W = g / 4;
    localparam int L = g % 4;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_o[g*8 +: 8] <= '0;
      else if (fill_i && fill_word_i == W[$bits(fill_word_i)-1:0])
        data_o[g*8 +: 8] <= fill_data_i[L*8 +: 8];
      else if (wr_i && wr_word_i == W[$bits(wr_word_i)-1:0] && wr_be_i[L])
        data_o[g*8 +: 8] <= wr_data_i[L*8 +: 8];
    end
  end
endmodule

// File: rtl/lbu_alloc.sv
module lbu_alloc
  import lbu_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  line_st_e       st_i [NUM_LINES],
  input  logic           adv_i,
  output logic           free_o,
  output logic [IDX_W-1:0] tgt_o
);
  logic [IDX_W-1:0] rr_q, free_idx;

  always_comb begin
    free_o   = 1'b0;
    free_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (st_i[i] == LN_EMPTY) begin
        free_o   = 1'b1;
        free_idx = i[IDX_W-1:0];
      end
    end
    tgt_o = free_o ? free_idx : rr_q;
  end

  // victim pointer moves only when a full set forced a choice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (adv_i && !free_o) begin
      if (rr_q == IDX_W'(NUM_LINES - 1)) rr_q <= '0;
      else rr_q <= rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/line_buffer_unit.sv
module line_buffer_unit
  import lbu_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exp_req_i,
  input  logic              exp_we_i,
  input  logic [ADDR_W-1:0] exp_addr_i,
  input  logic [3:0]        exp_be_i,
  input  logic [31:0]       exp_wdata_i,
  output logic              exp_wait_o,
  output logic [31:0]       exp_rdata_o,
  input  logic              flush_i,
  output logic              sys_valid_o,
  input  logic              sys_ready_i,
  output logic              sys_we_o,
  output logic [ADDR_W-1:0] sys_addr_o,
  output logic [3:0]        sys_be_o,
  output logic [31:0]       sys_wdata_o,
  input  logic [31:0]       sys_rdata_i,
  output logic              sys_last_o
);
  localparam int WORDS = LINE_BYTES / 4;
  localparam int WB    = $clog2(WORDS);
  localparam int OFS   = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFS;
  localparam int IDX_W = $clog2(NUM_LINES);

  line_st_e              ln_st   [NUM_LINES];
  logic [TAG_W-1:0]      ln_tag  [NUM_LINES];
  logic [LINE_BYTES-1:0] ln_mask [NUM_LINES];
  logic [LINE_BYTES*8-1:0] ln_data [NUM_LINES];
  logic [NUM_LINES-1:0]  ln_load, ln_set, ln_wr, ln_fill;
  line_st_e              st_in;

  fsm_e             fsm_q, fsm_n;
  logic [IDX_W-1:0] cur_q, cur_n;
  logic [WB-1:0]    beat_q, beat_n;
  logic             flush_pend_q;

  logic [TAG_W-1:0] req_tag;
  logic [WB-1:0]    req_word;
  logic             hit_any, wr_any, full_any, free_any, accept, adv;
  logic [IDX_W-1:0] hit_idx, wr_idx, full_idx, tgt_idx;

  assign req_tag  = exp_addr_i[ADDR_W-1:OFS];
  assign req_word = exp_addr_i[OFS-1:2];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    lbu_line #(.LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)) i_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (ln_load[i]),
      .tag_i       (req_tag),
      .st_set_i    (ln_set[i]),
      .st_i        (st_in),
      .wr_i        (ln_wr[i]),
      .wr_word_i   (req_word),
      .wr_be_i     (exp_be_i),
      .wr_data_i   (exp_wdata_i),
      .fill_i      (ln_fill[i]),
      .fill_word_i (beat_q),
      .fill_data_i (sys_rdata_i),
      .st_o        (ln_st[i]),
      .tag_o       (ln_tag[i]),
      .mask_o      (ln_mask[i]),
      .data_o      (ln_data[i])
    );
  end

  lbu_alloc #(.NUM_LINES(NUM_LINES)) i_alloc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .st_i   (ln_st),
    .adv_i  (adv),
    .free_o (free_any),
    .tgt_o  (tgt_idx)
  );

  // lowest-index search for hit, posted and complete lines
  always_comb begin
    hit_any = 1'b0; hit_idx = '0;
    wr_any = 1'b0;  wr_idx = '0;
    full_any = 1'b0; full_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (ln_st[i] != LN_EMPTY && ln_tag[i] == req_tag) begin
        hit_any = 1'b1; hit_idx = i[IDX_W-1:0];
      end
      if (ln_st[i] == LN_POSTED) begin
        wr_any = 1'b1; wr_idx = i[IDX_W-1:0];
        if (&ln_mask[i]) begin
          full_any = 1'b1; full_idx = i[IDX_W-1:0];
        end
      end
    end
  end

  always_comb begin
    fsm_n   = fsm_q;
    cur_n   = cur_q;
    beat_n  = beat_q;
    accept  = 1'b0;
    adv     = 1'b0;
    ln_load = '0;
    ln_set  = '0;
    ln_wr   = '0;
    ln_fill = '0;
    st_in   = LN_EMPTY;
    unique case (fsm_q)
      FS_IDLE: begin
        beat_n = '0;
        if (full_any) begin
          fsm_n = FS_FLUSH; cur_n = full_idx;
        end else if (flush_pend_q && wr_any) begin
          fsm_n = FS_FLUSH; cur_n = wr_idx;
        end else if (exp_req_i && exp_we_i) begin
          if (hit_any && ln_st[hit_idx] == LN_POSTED) begin
            ln_wr[hit_idx] = 1'b1;
            accept = 1'b1;
          end else if (hit_any) begin
            // prefetched copy is dropped, line restarts as posted
            ln_load[hit_idx] = 1'b1; ln_set[hit_idx] = 1'b1; st_in = LN_POSTED;
            ln_wr[hit_idx] = 1'b1;
            accept = 1'b1;
          end else if (ln_st[tgt_idx] == LN_POSTED) begin
            fsm_n = FS_FLUSH; cur_n = tgt_idx; adv = 1'b1;
          end else begin
            ln_load[tgt_idx] = 1'b1; ln_set[tgt_idx] = 1'b1; st_in = LN_POSTED;
            ln_wr[tgt_idx] = 1'b1;
            accept = 1'b1; adv = 1'b1;
          end
        end else if (exp_req_i) begin
          if (hit_any && ln_st[hit_idx] == LN_PREFETCH) begin
            accept = 1'b1;
          end else if (wr_any) begin
            fsm_n = FS_FLUSH; cur_n = wr_idx;
          end else begin
            ln_load[tgt_idx] = 1'b1; ln_set[tgt_idx] = 1'b1; st_in = LN_FILLING;
            fsm_n = FS_FILL; cur_n = tgt_idx; adv = 1'b1;
          end
        end
      end
      FS_FLUSH: begin
        if (sys_ready_i) begin
          beat_n = beat_q + 1'b1;
          if (beat_q == WB'(WORDS - 1)) begin
            ln_set[cur_q] = 1'b1; st_in = LN_EMPTY; fsm_n = FS_IDLE;
          end
        end
      end
      FS_FILL: begin
        if (sys_ready_i) begin
          ln_fill[cur_q] = 1'b1;
          beat_n = beat_q + 1'b1;
          if (beat_q == WB'(WORDS - 1)) begin
            ln_set[cur_q] = 1'b1; st_in = LN_PREFETCH; fsm_n = FS_IDLE;
          end
        end
      end
      default: fsm_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q        <= FS_IDLE;
      cur_q        <= '0;
      beat_q       <= '0;
      flush_pend_q <= 1'b0;
    end else begin
      fsm_q        <= fsm_n;
      cur_q        <= cur_n;
      beat_q       <= beat_n;
      flush_pend_q <= flush_i | (flush_pend_q & wr_any);
    end
  end

  assign exp_wait_o  = exp_req_i & ~accept;
  assign exp_rdata_o = ln_data[hit_idx][req_word*32 +: 32];
  assign sys_valid_o = (fsm_q != FS_IDLE);
  assign sys_we_o    = (fsm_q == FS_FLUSH);
  assign sys_addr_o  = {ln_tag[cur_q], beat_q, 2'b00};
  assign sys_be_o    = (fsm_q == FS_FLUSH) ? ln_mask[cur_q][beat_q*4 +: 4] : 4'hf;
  assign sys_wdata_o = ln_data[cur_q][beat_q*32 +: 32];
  assign sys_last_o  = sys_valid_o && (beat_q == WB'(WORDS - 1));
endmodule

// File: rtl/lbu_chk.sv
module lbu_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exp_req_i,
  input logic              exp_wait_o,
  input logic              sys_valid_o,
  input logic              sys_ready_i,
  input logic              sys_we_o,
  input logic [ADDR_W-1:0] sys_addr_o,
  input logic [3:0]        sys_be_o,
  input logic [31:0]       sys_wdata_o,
  input logic              sys_last_o
);
  localparam int OFS = $clog2(LINE_BYTES);

  // R10
  sys_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_valid_o && !sys_ready_i |=> sys_valid_o && $stable(sys_addr_o) && $stable(sys_we_o)
      && $stable(sys_be_o) && $stable(sys_wdata_o));

  // R3
  burst_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_valid_o) |-> sys_addr_o[OFS-1:0] == '0);

  // R3
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_valid_o && sys_ready_i && !sys_last_o |=> sys_valid_o && sys_addr_o == $past(sys_addr_o) + 4);

  // R9
  busy_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_valid_o && exp_req_i |-> exp_wait_o);

  // R9
  idle_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exp_req_i |-> !exp_wait_o);

  // R5
  fill_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_valid_o && !sys_we_o |-> sys_be_o == 4'hf);
endmodule

bind line_buffer_unit lbu_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_lbu_chk (.*);

// File: tb/test_line_buffer_unit.sv
`timescale 1ns/1ps
module test_line_buffer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exp_req = 1'b0, exp_we = 1'b0;
  logic [31:0] exp_addr = '0, exp_wdata = '0;
  logic [3:0]  exp_be = '0;
  logic        exp_wait;
  logic [31:0] exp_rdata;
  logic        flush = 1'b0;
  logic        sys_valid, sys_ready = 1'b1, sys_we, sys_last;
  logic [31:0] sys_addr, sys_wdata, sys_rdata = '0;
  logic [3:0]  sys_be;

  int n_chk = 0, n_fail = 0;
  int stall_en = 0, stall_ctr = 0;
  int lg_n = 0;
  logic        lg_we   [64];
  logic [31:0] lg_addr [64];
  logic [3:0]  lg_be   [64];
  logic [31:0] lg_data [64];

  line_buffer_unit i_line_buffer_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .exp_req_i(exp_req), .exp_we_i(exp_we), .exp_addr_i(exp_addr), .exp_be_i(exp_be),
    .exp_wdata_i(exp_wdata), .exp_wait_o(exp_wait), .exp_rdata_o(exp_rdata),
    .flush_i(flush),
    .sys_valid_o(sys_valid), .sys_ready_i(sys_ready), .sys_we_o(sys_we),
    .sys_addr_o(sys_addr), .sys_be_o(sys_be), .sys_wdata_o(sys_wdata),
    .sys_rdata_i(sys_rdata), .sys_last_o(sys_last)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'h5a5a_0000;
  endfunction

  // system-side responder and beat log
  always @(negedge clk) begin
    stall_ctr++;
    sys_ready = !(stall_en != 0 && stall_ctr[0]);
    #1;
    sys_rdata = mem_word(sys_addr);
    if (rst_n && sys_valid && sys_ready && lg_n < 64) begin
      lg_we[lg_n] = sys_we; lg_addr[lg_n] = sys_addr;
      lg_be[lg_n] = sys_be; lg_data[lg_n] = sys_wdata;
      lg_n++;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_beat(input int k, input logic we, input logic [31:0] a, input logic [3:0] be, input string rq);
    chk(lg_we[k] == we && lg_addr[k] == a && lg_be[k] == be, rq,
        {lg_we[k], lg_be[k], lg_addr[k][23:0]}, {we, be, a[23:0]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lg_n = 0;
  endtask

  task automatic acc(input logic we, input logic [31:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    exp_req = 1'b1; exp_we = we; exp_addr = a; exp_be = be; exp_wdata = wd;
    waits = 0;
    #2;
    while (exp_wait) begin
      waits++;
      @(negedge clk);
      #2;
    end
    rd = exp_rdata;
    @(posedge clk);
    #1 exp_req = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (sys_valid) @(negedge clk);
    #2;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    #2;
    chk(exp_wait == 1'b0, "R1 wait after reset", exp_wait, 0);
    chk(sys_valid == 1'b0, "R1 valid after reset", sys_valid, 0);
  endtask

  task automatic t_read_fill();
    logic [31:0] rd; int w;
    lg_n = 0;
    acc(1'b0, 32'h104, 4'h0, '0, rd, w);
    chk(lg_n == 4, "R1 R5 fill beats", lg_n, 4);
    for (int k = 0; k < 4; k++) chk_beat(k, 1'b0, 32'h100 + 4 * k, 4'hf, "R5 fill beat");
    chk(rd == mem_word(32'h104), "R5 read data", rd, mem_word(32'h104));
    chk(w > 0, "R9 wait on miss", w, 1);
    acc(1'b0, 32'h108, 4'h0, '0, rd, w);
    chk(lg_n == 4, "R5 hit no system access", lg_n, 4);
    chk(rd == mem_word(32'h108), "R5 hit data", rd, mem_word(32'h108));
    chk(w == 0, "R9 hit no wait", w, 0);
  endtask

  task automatic t_merge_flush();
    logic [31:0] rd; int w;
    lg_n = 0;
    acc(1'b1, 32'h200, 4'b0001, 32'h0000_00aa, rd, w);
    acc(1'b1, 32'h201, 4'b0100, 32'h00bb_0000, rd, w);
    chk(w == 0, "R9 posted hit no wait", w, 0);
    acc(1'b1, 32'h208, 4'b0011, 32'h0000_ccdd, rd, w);
    chk(lg_n == 0, "R2 writes posted", lg_n, 0);
    pulse_flush();
    chk(lg_n == 4, "R4 flush beats", lg_n, 4);
    chk_beat(0, 1'b1, 32'h200, 4'b0101, "R4 beat0");
    chk_beat(1, 1'b1, 32'h204, 4'b0000, "R4 beat1");
    chk_beat(2, 1'b1, 32'h208, 4'b0011, "R4 beat2");
    chk_beat(3, 1'b1, 32'h20c, 4'b0000, "R4 beat3");
    chk((lg_data[0] & 32'h00ff_00ff) == 32'h00bb_00aa, "R2 merged lanes", lg_data[0], 32'h00bb_00aa);
    chk(lg_data[2][15:0] == 16'hccdd, "R2 word lanes", lg_data[2], 32'hccdd);
  endtask

  task automatic t_full_line();
    logic [31:0] rd; int w;
    lg_n = 0;
    stall_en = 1;
    for (int k = 0; k < 4; k++) acc(1'b1, 32'h300 + 4 * k, 4'hf, 32'h1000 + k, rd, w);
    wait_idle();
    stall_en = 0;
    chk(lg_n == 4, "R3 auto flush beats", lg_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk_beat(k, 1'b1, 32'h300 + 4 * k, 4'hf, "R3 full beat");
      chk(lg_data[k] == 32'h1000 + k, "R10 data under stall", lg_data[k], 32'h1000 + k);
    end
  endtask

  task automatic t_read_order();
    logic [31:0] rd; int w;
    lg_n = 0;
    acc(1'b1, 32'h400, 4'hf, 32'h4444_4444, rd, w);
    acc(1'b0, 32'h500, 4'h0, '0, rd, w);
    chk(lg_n == 8, "R6 beat count", lg_n, 8);
    chk_beat(0, 1'b1, 32'h400, 4'hf, "R6 flush first");
    chk_beat(3, 1'b1, 32'h40c, 4'h0, "R6 flush last");
    chk_beat(4, 1'b0, 32'h500, 4'hf, "R6 fill after");
    chk(rd == mem_word(32'h500), "R6 read data", rd, mem_word(32'h500));
  endtask

  task automatic t_invalidate();
    logic [31:0] rd; int w;
    lg_n = 0;
    acc(1'b1, 32'h104, 4'hf, 32'h7777_7777, rd, w);
    chk(w == 0 && lg_n == 0, "R7 write to prefetched line accepted", lg_n, 0);
    acc(1'b0, 32'h108, 4'h0, '0, rd, w);
    chk(lg_n == 8, "R7 refetch beats", lg_n, 8);
    chk_beat(1, 1'b1, 32'h104, 4'hf, "R7 posted write flushed");
    chk_beat(0, 1'b1, 32'h100, 4'h0, "R7 stale bytes not written");
    chk_beat(4, 1'b0, 32'h100, 4'hf, "R7 line fetched again");
    chk(rd == mem_word(32'h108), "R7 read data", rd, mem_word(32'h108));
  endtask

  task automatic t_round_robin();
    logic [31:0] rd; int w;
    do_reset();
    for (int k = 1; k <= 4; k++) acc(1'b1, 32'h1000 * k, 4'hf, 32'hab00 + k, rd, w);
    chk(lg_n == 0, "R8 four lines held", lg_n, 0);
    acc(1'b1, 32'h5000, 4'hf, 32'h55, rd, w);
    wait_idle();
    chk(lg_n == 4, "R8 victim flush beats", lg_n, 4);
    chk_beat(0, 1'b1, 32'h1000, 4'hf, "R8 first victim");
    chk_beat(1, 1'b1, 32'h1004, 4'h0, "R8 first victim beat1");
    chk(lg_data[0] == 32'hab01, "R8 victim data", lg_data[0], 32'hab01);
    lg_n = 0;
    acc(1'b1, 32'h6000, 4'hf, 32'h66, rd, w);
    wait_idle();
    chk(lg_n == 4, "R8 second victim beats", lg_n, 4);
    chk_beat(0, 1'b1, 32'h2000, 4'hf, "R8 second victim");
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_read_fill();
    t_merge_flush();
    t_full_line();
    t_read_order();
    t_invalidate();
    t_round_robin();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule